// File: doc/BRIEF.md
# Track Signal Encoder with Feedback Cutout

This block turns a stream of packet bytes into the bipolar bitstream that drives a model-railway track bridge. Every bit is a high half-period followed by a low half-period of the same length. A short half means a one and a long half means a zero. A packet is built from four parts in order: a run of one bits, the data bytes, a check byte, and a closing one bit. Each data byte is preceded by a zero bit. The check byte is computed inside the block.

Once the closing bit has ended, the block can open a feedback window if the cutout enable is high. The bridge first holds its high level for a short settling delay. It is then braked for the rest of the window, and a cutout flag is raised for the same span. The next run of preamble ones starts only after the window has closed. That run is lengthened after a window, because the closing bit can no longer merge with it. When nothing is queued, the block keeps sending one bits. All timing is counted in 1 µs ticks, which are derived from a clock-per-microsecond parameter.

Top module: `dcc_cutout_gen`

## Requirements
- R1: A one bit is a high half followed by a low half, and each half lasts ONE_HALF_US (58) µs.
- R2: A zero bit is a high half followed by a low half, and each half lasts ZERO_HALF_US (100) µs.
- R3: The order of a packet is fixed. Preamble ones come first. Each data byte follows as one zero bit and then the byte's eight bits, most significant first. After the last data byte comes one zero bit, then the check byte (MSB first), then a single one bit that ends the packet.
- R4: The check byte is the XOR of all the data bytes of the packet, so n data bytes produce exactly n+1 bytes on the track.
- R5: From reset, and after a packet sent without a cutout, exactly PRE_BITS (16) preamble ones come before the first zero bit, provided the first byte of the next packet is already waiting. While no byte is waiting, one bits go on being sent.
- R6: After a packet that was followed by a cutout, exactly PRE_BITS+PRE_EXTRA (18) preamble ones come before the first zero bit.
- R7: cutout_en is sampled when the closing one bit ends. If it is 1, the polarity stays high for GAP_US (29) µs with brake and flag low. Brake and flag are then both high, with the polarity still high, for WINDOW_US−GAP_US (439) µs. Both are released together when the next preamble begins. The closing bit and the last check-byte bit always keep their full length.
- R8: If cutout_en is 0 when the closing bit ends, the high half of the first preamble bit follows at once, and brake and flag stay low.
- R9: in_ready is high for one clock at the bit boundary where a byte is due. A byte is taken only when in_valid and in_ready are both high. A byte taken with in_last high is the last data byte of its packet.
- R10: While reset is asserted, track_pol is high and track_brake, cutout_active and in_ready are low.
- R11: Every duration scales with CLKS_PER_US. A one-bit half lasts 58·CLKS_PER_US clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_data | input | 8 | Packet data byte |
| in_valid | input | 1 | in_data holds a byte |
| in_last | input | 1 | This byte is the last data byte of its packet |
| in_ready | output | 1 | The block takes a byte this clock if in_valid is high |
| cutout_en | input | 1 | Open a feedback window after the closing bit |
| track_pol | output | 1 | Bridge polarity (1 = high half) |
| track_brake | output | 1 | Bridge braked, both sides tied |
| cutout_active | output | 1 | Feedback window in progress |

## Verification
The bench decodes the track waveform back into bits by measuring the length of each run of equal output levels. It then rebuilds each packet and compares it with packets the bench generated itself: one to three bytes each, including all-ones and all-zeros bytes, and a spread of values whose check byte ends in both a 0 and a 1. The cutout enable is switched on and off between packets. This shows that the window never shortens the closing bit and that the next preamble's length depends on whether a window came before it. One packet is held back long enough to force idle ones, which separates "preamble reached" from "byte waiting". A second instance with three clocks per microsecond shows that the timing scales with the clock.

// File: rtl/dcc_gen_pkg.sv
package dcc_gen_pkg;

  typedef enum logic [2:0] {
    ST_PRE  = 3'd0,
    ST_SEP  = 3'd1,
    ST_DATA = 3'd2,
    ST_XSEP = 3'd3,
    ST_XOR  = 3'd4,
    ST_END  = 3'd5,
    ST_GAP  = 3'd6,
    ST_CUT  = 3'd7
  } dcc_state_e;

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/dcc_rst_sync.sv
module dcc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n = sync_q;

endmodule

// File: rtl/dcc_us_tick.sv
module dcc_us_tick #(
  parameter int unsigned CLKS_PER_US = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int unsigned PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

  logic [PW-1:0] presc_q;
  logic [PW-1:0] presc_d;

  assign tick = (presc_q == PW'(CLKS_PER_US - 1));

  always_comb begin
    presc_d = presc_q;
    if (tick) presc_d = '0;
    else      presc_d = presc_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end

endmodule

// File: rtl/dcc_seg_timer.sv
module dcc_seg_timer #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] seg_len,
  output logic             seg_end
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign seg_end = tick && (cnt_q == seg_len - CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (seg_end) cnt_d = '0;
      else         cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < seg_len); // R11

endmodule

// File: rtl/dcc_pkt_ctrl.sv
module dcc_pkt_ctrl
  import dcc_gen_pkg::*;
#(
  parameter int unsigned PRE_BITS     = 16,
  parameter int unsigned PRE_EXTRA    = 2,
  parameter int unsigned ONE_HALF_US  = 58,
  parameter int unsigned ZERO_HALF_US = 100,
  parameter int unsigned GAP_US       = 29,
  parameter int unsigned CUT_US       = 439,
  parameter int unsigned CNT_W        = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_end,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             cut_en,
  output logic             in_ready,
  output logic [CNT_W-1:0] seg_len,
  output dcc_state_e       state_o,
  output logic             half_o
);

  localparam int unsigned PC_W = $clog2(PRE_BITS + PRE_EXTRA + 2);

  dcc_state_e      state_q, state_d;
  logic            half_q, half_d;
  logic [2:0]      idx_q, idx_d;
  logic [PC_W-1:0] pre_q, pre_d;
  logic [7:0]      shreg_q, shreg_d;
  logic [7:0]      xor_q, xor_d;
  logic            last_q, last_d;
  logic            cutprev_q, cutprev_d;

  logic            bit_val;
  logic            is_bit;
  logic            bit_end;
  logic [PC_W-1:0] pre_tgt;
  logic            pre_full;
  logic            take;

  always_comb begin
    unique case (state_q)
      ST_SEP, ST_XSEP: bit_val = 1'b0;
      ST_DATA, ST_XOR: bit_val = shreg_q[7];
      default:         bit_val = 1'b1;
    endcase
  end

  assign is_bit  = (state_q != ST_GAP) && (state_q != ST_CUT);
  assign bit_end = seg_end && is_bit && half_q;

  always_comb begin
    if (state_q == ST_GAP)      seg_len = CNT_W'(GAP_US);
    else if (state_q == ST_CUT) seg_len = CNT_W'(CUT_US);
    else if (bit_val)           seg_len = CNT_W'(ONE_HALF_US);
    else                        seg_len = CNT_W'(ZERO_HALF_US);
  end

  assign pre_tgt  = cutprev_q ? PC_W'(PRE_BITS + PRE_EXTRA) : PC_W'(PRE_BITS);
  assign pre_full = (pre_q + PC_W'(1)) >= pre_tgt;

  assign in_ready = bit_end &&
                    (((state_q == ST_PRE) && pre_full) ||
                     ((state_q == ST_DATA) && (idx_q == 3'd7) && !last_q));
  assign take = in_ready && in_valid;

  always_comb begin
    state_d   = state_q;
    half_d    = half_q;
    idx_d     = idx_q;
    pre_d     = pre_q;
    shreg_d   = shreg_q;
    xor_d     = xor_q;
    last_d    = last_q;
    cutprev_d = cutprev_q;

    if (seg_end && is_bit) half_d = ~half_q;

    if (bit_end) begin
      unique case (state_q)
        ST_PRE: begin
          if (take) begin
            state_d = ST_SEP;
            shreg_d = in_data;
            xor_d   = in_data;
            last_d  = in_last;
          end else if (pre_q < pre_tgt) begin
            pre_d = pre_q + PC_W'(1);
          end
        end
        ST_SEP: begin
          state_d = ST_DATA;
          idx_d   = 3'd0;
        end
        ST_DATA: begin
          shreg_d = {shreg_q[6:0], 1'b0};
          idx_d   = idx_q + 3'd1;
          if (idx_q == 3'd7) begin
            if (take) begin
              state_d = ST_SEP;
              shreg_d = in_data;
              xor_d   = xor_q ^ in_data;
              last_d  = in_last;
            end else begin
              state_d = ST_XSEP;
              shreg_d = xor_q;
            end
          end
        end
        ST_XSEP: begin
          state_d = ST_XOR;
          idx_d   = 3'd0;
        end
        ST_XOR: begin
          shreg_d = {shreg_q[6:0], 1'b0};
          idx_d   = idx_q + 3'd1;
          if (idx_q == 3'd7) state_d = ST_END;
        end
        ST_END: begin
          pre_d = '0;
          if (cut_en) begin
            state_d   = ST_GAP;
            cutprev_d = 1'b1;
          end else begin
            state_d   = ST_PRE;
            cutprev_d = 1'b0;
          end
        end
        default: ;
      endcase
    end else if (seg_end && (state_q == ST_GAP)) begin
      state_d = ST_CUT;
    end else if (seg_end && (state_q == ST_CUT)) begin
      state_d = ST_PRE;
      pre_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_PRE;
      half_q    <= 1'b0;
      idx_q     <= '0;
      pre_q     <= '0;
      shreg_q   <= '0;
      xor_q     <= '0;
      last_q    <= 1'b0;
      cutprev_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      half_q    <= half_d;
      idx_q     <= idx_d;
      pre_q     <= pre_d;
      shreg_q   <= shreg_d;
      xor_q     <= xor_d;
      last_q    <= last_d;
      cutprev_q <= cutprev_d;
    end
  end

  assign state_o = state_q;
  assign half_o  = half_q;

  AST_TAKE_ENTERS_SEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> (state_q == ST_SEP)); // R9
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready); // R9
  AST_PRE_LONG_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SEP) && ($past(state_q) == ST_PRE)) |-> ($past(pre_q) >= PC_W'(PRE_BITS - 1))); // R5
  AST_CHECK_AFTER_SEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_XOR) && ($past(state_q) != ST_XOR)) |-> ($past(state_q) == ST_XSEP)); // R3
  AST_GAP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_GAP) && ($past(state_q) != ST_GAP)) |-> (($past(state_q) == ST_END) && $past(cut_en))); // R7

endmodule

// File: rtl/dcc_cutout_gen.sv
module dcc_cutout_gen
  import dcc_gen_pkg::*;
#(
  parameter int unsigned CLKS_PER_US  = 16,
  parameter int unsigned ONE_HALF_US  = 58,
  parameter int unsigned ZERO_HALF_US = 100,
  parameter int unsigned PRE_BITS     = 16,
  parameter int unsigned PRE_EXTRA    = 2,
  parameter int unsigned GAP_US       = 29,
  parameter int unsigned WINDOW_US    = 468
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  input  logic       cutout_en,
  output logic       track_pol,
  output logic       track_brake,
  output logic       cutout_active
);

  localparam int unsigned CUT_US = WINDOW_US - GAP_US;
  localparam int unsigned MAX_US = max_of4(ONE_HALF_US, ZERO_HALF_US, GAP_US, CUT_US);
  localparam int unsigned CNT_W  = $clog2(MAX_US + 1);

  logic             rst_n;
  logic             tick;
  logic             seg_end;
  logic [CNT_W-1:0] seg_len;
  dcc_state_e       state;
  logic             half;
  logic             in_window;

  dcc_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  dcc_us_tick #(
    .CLKS_PER_US (CLKS_PER_US)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  dcc_seg_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .seg_len (seg_len),
    .seg_end (seg_end)
  );

  dcc_pkt_ctrl #(
    .PRE_BITS     (PRE_BITS),
    .PRE_EXTRA    (PRE_EXTRA),
    .ONE_HALF_US  (ONE_HALF_US),
    .ZERO_HALF_US (ZERO_HALF_US),
    .GAP_US       (GAP_US),
    .CUT_US       (CUT_US),
    .CNT_W        (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .seg_end  (seg_end),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_last  (in_last),
    .cut_en   (cutout_en),
    .in_ready (in_ready),
    .seg_len  (seg_len),
    .state_o  (state),
    .half_o   (half)
  );

  assign in_window     = (state == ST_GAP) || (state == ST_CUT);
  assign track_pol     = in_window ? 1'b1 : ~half;
  assign track_brake   = (state == ST_CUT);
  assign cutout_active = (state == ST_CUT);

  AST_BRAKE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track_brake) |-> ($past(track_pol) && !$past(cutout_active))); // R7

endmodule

// File: tb/dcc_cutout_gen_tb.sv
module dcc_cutout_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 12;
  localparam int PRE        = 16;
  localparam int EXTRA      = 2;
  localparam int ONE_L      = 58;
  localparam int ZERO_L     = 100;
  localparam int GAP_L      = 29;
  localparam int CUT_L      = 468 - 29;
  localparam int IDLE_P     = 6;
  localparam int SLOW_CPU   = 3;

  logic       clk = 1'b0;
  logic       arst_n;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_last;
  logic       in_ready;
  logic       cutout_en;
  logic       track_pol;
  logic       track_brake;
  logic       cutout_active;
  logic       s_ready, s_pol, s_brake, s_cut;

  int nchk = 0;
  int nfail = 0;
  int acc_cnt = 0;
  int dbl_cnt = 0;
  logic prev_ready = 1'b0;
  bit done = 1'b0;

  logic [7:0] pk_data [NP][3];
  int         pk_len  [NP];
  bit         pk_cut  [NP];
  logic [2:0] nk;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcc_cutout_gen #(.CLKS_PER_US(1)) u_dut (
    .clk(clk), .arst_n(arst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .cutout_en(cutout_en),
    .track_pol(track_pol), .track_brake(track_brake), .cutout_active(cutout_active)
  );

  dcc_cutout_gen #(.CLKS_PER_US(SLOW_CPU)) u_dut_slow (
    .clk(clk), .arst_n(arst_n), .in_data(8'h00), .in_valid(1'b0),
    .in_last(1'b0), .in_ready(s_ready), .cutout_en(1'b0),
    .track_pol(s_pol), .track_brake(s_brake), .cutout_active(s_cut)
  );

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (arst_n) begin
      if (in_ready && prev_ready) dbl_cnt++;
      if (in_ready && in_valid) acc_cnt++;
      prev_ready = in_ready;
    end
  end

  task automatic get_run(output logic [2:0] key, output int len);
    key = nk;
    len = 0;
    do begin
      len++;
      @(negedge clk);
      nk = {track_brake, cutout_active, track_pol};
    end while (nk == key);
  endtask

  task automatic get_bit(output int b);
    logic [2:0] k1, k2;
    int l1, l2;
    get_run(k1, l1);
    get_run(k2, l2);
    nchk++;
    if (k1 == 3'b001 && k2 == 3'b000 && l1 == l2 && l1 == ONE_L) b = 1;
    else if (k1 == 3'b001 && k2 == 3'b000 && l1 == l2 && l1 == ZERO_L) b = 0;
    else begin
      b = -1;
      nfail++;
      $display("FAIL R1/R2 bit halves actual=%0d/%0d keys %b/%b expected=%0d or %0d each, keys 001/000",
               l1, l2, k1, k2, ONE_L, ZERO_L);
    end
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      pk_len[p] = (p % 3) + 1;
      pk_cut[p] = ((p % 4) == 1) || ((p % 4) == 2) || (p == 7);
      for (int i = 0; i < 3; i++)
        pk_data[p][i] = 8'((p * 37 + i * 101 + 5) & 255);
    end
    pk_data[0][0] = 8'hFF;
    pk_data[1][0] = 8'h00;
    pk_data[1][1] = 8'h01;
    pk_data[2][0] = 8'h80;
    pk_data[2][1] = 8'h7F;
    pk_data[2][2] = 8'hAA;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [2:0] k;
    int l, b, cnt, nb, tgt;
    logic [7:0] got [8];
    logic [7:0] xr, by;

    arst_n    = 1'b0;
    in_data   = 8'h00;
    in_valid  = 1'b0;
    in_last   = 1'b0;
    cutout_en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 pol in reset", int'(track_pol), 1);
    chk("R10 brake in reset", int'(track_brake), 0);
    chk("R10 flag in reset", int'(cutout_active), 0);
    chk("R10 ready in reset", int'(in_ready), 0);
    arst_n = 1'b1;

    fork
      begin : driver
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
          if (p == IDLE_P) repeat (6000) @(negedge clk);
          for (int i = 0; i < pk_len[p]; i++) begin
            in_data  = pk_data[p][i];
            in_valid = 1'b1;
            in_last  = (i == pk_len[p] - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
          end
          in_valid = 1'b0;
          in_last  = 1'b0;
        end
      end
      begin : slow_scale
        int lo, hi;
        @(negedge clk);
        while (s_pol) @(negedge clk);
        lo = 0;
        while (!s_pol) begin lo++; @(negedge clk); end
        hi = 0;
        while (s_pol) begin hi++; @(negedge clk); end
        chk("R11 low half at 3 clk/us", lo, ONE_L * SLOW_CPU);
        chk("R11 high half at 3 clk/us", hi, ONE_L * SLOW_CPU);
      end
    join_none

    @(negedge clk);
    nk = {track_brake, cutout_active, track_pol};
    do get_run(k, l); while (k != 3'b000);

    for (int p = 0; p < NP; p++) begin
      cnt = 0;
      do begin
        get_bit(b);
        if (b == 1) cnt++;
      end while (b == 1);
      tgt = PRE + ((p > 0 && pk_cut[p-1]) ? EXTRA : 0);
      if (p == 0)                chk("R5 preamble after reset", cnt, PRE - 1);
      else if (p == IDLE_P)      chk("R5 idle ones exceed preamble", int'(cnt > tgt), 1);
      else if (pk_cut[p-1])      chk("R6 preamble after cutout", cnt, tgt);
      else                       chk("R5 preamble without cutout", cnt, tgt);
      chk("R3 separator is zero", b, 0);
      cutout_en = pk_cut[p];

      nb = 0;
      forever begin
        by = 8'h00;
        for (int j = 0; j < 8; j++) begin
          get_bit(b);
          by = {by[6:0], b[0]};
        end
        got[nb] = by;
        nb++;
        get_bit(b);
        if (b != 0 || nb >= 8) break;
      end
      chk("R3 closing one bit", b, 1);
      chk("R4 byte count", nb, pk_len[p] + 1);
      xr = 8'h00;
      for (int i = 0; i < pk_len[p]; i++) begin
        xr ^= pk_data[p][i];
        if (i < nb) chk("R3 data byte", int'(got[i]), int'(pk_data[p][i]));
      end
      if (nb == pk_len[p] + 1) chk("R4 check byte", int'(got[nb-1]), int'(xr));

      if (pk_cut[p]) begin
        get_run(k, l);
        chk("R7 settle key", int'(k), 3'b001);
        chk("R7 settle length", l, GAP_L);
        get_run(k, l);
        chk("R7 brake+flag key", int'(k), 3'b111);
        chk("R7 brake length", l, CUT_L);
        chk("R7 released into preamble", int'(nk), 3'b001);
      end else begin
        chk("R8 no window after closing bit", int'(nk), 3'b001);
      end
    end

    chk("R9 bytes accepted", acc_cnt, 2 + 3 + 1 + 2 + 3 + 1 + 2 + 3 + 1 + 2 + 3 + 1);
    chk("R9 ready never two clocks", dbl_cnt, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule